// File: doc/BRIEF.md
# Flux Interval Carry-Token Decoder

This block turns a compact byte stream of flux-transition timings back into full-width interval counts. Each byte uses its low seven bits for timing and its top bit as a marker flag. An interval longer than one byte can hold is sent as a run of carry tokens followed by one completing byte. A carry token is any byte whose low seven bits are all zero. Each token adds a fixed weight of 127 to a running accumulator. The completing byte adds its low seven bits, and the block then emits the total together with that byte's flag.

The stream arrives one byte per cycle with a valid strobe and has no back-pressure, so a byte is accepted on every cycle where valid is high. Each rebuilt interval appears as a 16-bit word with a one-cycle output strobe, in the cycle after its completing byte is accepted. If a run of carries or a final addition would go past the 16-bit range, the value saturates at 65535 and a sticky error output is raised.

Top module: `flux_interval_decoder`

## Requirements
- R1: After reset, out_valid, out_value, out_flag and err are all 0, and the accumulator is zero, so a first byte of 0x05 yields an interval of 5.
- R2: A byte accepted with in_byte[6:0] == 0 (0x00 or 0x80) is a carry token. It adds 127 to the accumulator and produces no output strobe.
- R3: An accepted byte with in_byte[6:0] != 0 completes an interval. out_value equals the accumulator plus in_byte[6:0].
- R4: out_flag equals in_byte[7] of the completing byte, and that bit never adds to out_value.
- R5: The accumulator returns to zero after every completed interval, so the next interval does not depend on earlier ones.
- R6: out_valid is high for exactly one cycle per completed interval, in the cycle after the completing byte is accepted.
- R7: Bytes presented on consecutive cycles are all accepted, and each completing byte yields its own strobe.
- R8: A byte presented while in_valid is low has no effect: no strobe, and the accumulator does not change.
- R9: If a carry token would take the accumulator above 65535, the accumulator saturates at 65535 and err is set.
- R10: If the final addition would exceed 65535, out_value is 65535 and err is set. A total of exactly 65535 does not set err.
- R11: err stays high once set, until reset.
- R12: out_value and out_flag hold their last values while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe; the byte is accepted whenever this is high |
| in_byte | input | 8 | Encoded byte: [7] flag, [6:0] timing or zero for a carry |
| out_valid | output | 1 | One-cycle strobe for a completed interval |
| out_value | output | 16 | Rebuilt interval count |
| out_flag | output | 1 | Flag bit of the completing byte |
| err | output | 1 | Sticky accumulator overflow indication |

## Verification
A wrong accumulator value is not visible while carries are arriving. It shows up one cycle after the next completing byte, as a wrong out_value. A residue left over from a missed clear corrupts the interval that follows. A wrong token classification shows at once, as a missing or extra strobe in the following cycle. A saturation fault only shows near the 16-bit limit, so the bench drives runs of 516 and 517 carries to test both sides of the boundary.

// File: rtl/flux_dec_pkg.sv
package flux_dec_pkg;

    localparam int BYTE_W = 8;
    localparam int TIME_W = 7;

    typedef struct packed {
        logic              valid;
        logic              carry;
        logic              flag;
        logic [TIME_W-1:0] low;
    } tok_t;

    function automatic tok_t classify_byte(input logic v, input logic [BYTE_W-1:0] b);
        tok_t t;
        t.valid = v;
        t.low   = b[TIME_W-1:0];
        t.flag  = b[BYTE_W-1];
        t.carry = (b[TIME_W-1:0] == '0);
        return t;
    endfunction

endpackage

// File: rtl/fd_classify.sv
module fd_classify
    import flux_dec_pkg::*;
(
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output tok_t              tok
);
    always_comb tok = classify_byte(in_valid, in_byte);
endmodule

// File: rtl/fd_accum.sv
module fd_accum
    import flux_dec_pkg::*;
#(
    parameter int OUT_W        = 16,
    parameter int CARRY_WEIGHT = 127
) (
    input  logic             clk,
    input  logic             rst,
    input  tok_t             tok,
    output logic             cmp_valid,
    output logic [OUT_W-1:0] cmp_value,
    output logic             cmp_flag,
    output logic             ovf_evt
);
    localparam int               SUM_W  = OUT_W + 1;
    localparam logic [SUM_W-1:0] WEIGHT = SUM_W'(CARRY_WEIGHT);
    localparam logic [SUM_W-1:0] LIMIT  = {1'b0, {OUT_W{1'b1}}};

    logic [OUT_W-1:0] acc_q;
    logic [SUM_W-1:0] addend;
    logic [SUM_W-1:0] sum_wide;
    logic             ovf;
    logic [OUT_W-1:0] sum_sat;

    always_comb begin
        addend   = tok.carry ? WEIGHT : {{(SUM_W-TIME_W){1'b0}}, tok.low};
        sum_wide = {1'b0, acc_q} + addend;
        ovf      = (sum_wide > LIMIT);
        sum_sat  = ovf ? LIMIT[OUT_W-1:0] : sum_wide[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (tok.valid) begin
            acc_q <= tok.carry ? sum_sat : '0;
        end
    end

    assign cmp_valid = tok.valid && !tok.carry;
    assign cmp_value = sum_sat;
    assign cmp_flag  = tok.flag;
    assign ovf_evt   = tok.valid && ovf;
endmodule

// File: rtl/fd_emit.sv
module fd_emit #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_valid,
    input  logic [OUT_W-1:0] cmp_value,
    input  logic             cmp_flag,
    input  logic             ovf_evt,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_value,
    output logic             out_flag,
    output logic             err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_value <= '0;
            out_flag  <= 1'b0;
            err       <= 1'b0;
        end else begin
            out_valid <= cmp_valid;
            if (cmp_valid) begin
                out_value <= cmp_value;
                out_flag  <= cmp_flag;
            end
            if (ovf_evt) begin
                err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/flux_interval_decoder.sv
module flux_interval_decoder
    import flux_dec_pkg::*;
#(
    parameter int OUT_W        = 16,
    parameter int CARRY_WEIGHT = 127
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_value,
    output logic             out_flag,
    output logic             err
);
    tok_t             tok;
    logic             cmp_valid;
    logic [OUT_W-1:0] cmp_value;
    logic             cmp_flag;
    logic             ovf_evt;

    fd_classify u_cls (
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .tok      (tok)
    );

    fd_accum #(.OUT_W(OUT_W), .CARRY_WEIGHT(CARRY_WEIGHT)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .tok       (tok),
        .cmp_valid (cmp_valid),
        .cmp_value (cmp_value),
        .cmp_flag  (cmp_flag),
        .ovf_evt   (ovf_evt)
    );

    fd_emit #(.OUT_W(OUT_W)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .cmp_valid (cmp_valid),
        .cmp_value (cmp_value),
        .cmp_flag  (cmp_flag),
        .ovf_evt   (ovf_evt),
        .out_valid (out_valid),
        .out_value (out_value),
        .out_flag  (out_flag),
        .err       (err)
    );
endmodule

// File: rtl/fd_checker.sv
module fd_checker #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [7:0]       in_byte,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_value,
    input logic             out_flag,
    input logic             err
);
    // R6
    strobe_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R8
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    carry_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_byte[6:0] == 7'd0) |=> !out_valid);

    // R4
    flag_passthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_byte[6:0] != 7'd0) |=> (out_valid && out_flag == $past(in_byte[7])));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R12
    value_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_value) && $stable(out_flag)));
endmodule

bind flux_interval_decoder fd_checker #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .out_valid (out_valid),
    .out_value (out_value),
    .out_flag  (out_flag),
    .err       (err)
);

// File: tb/tb_flux_interval_decoder.sv
module tb_flux_interval_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic [15:0] out_value;
    logic        out_flag;
    logic        err;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // reference model state
    int m_acc = 0;
    int m_valid = 0, m_value = 0, m_flag = 0, m_err = 0;

    always #10 clk = ~clk;

    flux_interval_decoder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_value(out_value), .out_flag(out_flag), .err(err)
    );

    always @(posedge clk) begin
        int s;
        if (rst) begin
            m_acc = 0; m_valid = 0; m_value = 0; m_flag = 0; m_err = 0;
        end else begin
            m_valid = 0;
            if (in_valid) begin
                if (in_byte[6:0] == 7'd0) begin
                    s = m_acc + 127;
                    if (s > 65535) begin s = 65535; m_err = 1; end
                    m_acc = s;
                end else begin
                    s = m_acc + int'(in_byte[6:0]);
                    if (s > 65535) begin s = 65535; m_err = 1; end
                    m_valid = 1; m_value = s; m_flag = int'(in_byte[7]); m_acc = 0;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            cycles++;
            check("R6 out_valid", int'(out_valid), m_valid);
            check("R3 out_value", int'(out_value), m_value);
            check("R4 out_flag",  int'(out_flag),  m_flag);
            check("R9 err",       int'(err),       m_err);
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                done = 1'b1;
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic carries(input int n);
        for (int i = 0; i < n; i++) send(8'h00);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_value", int'(out_value), 0);
        check("R1 err", int'(err), 0);
        send(8'h05);
        check("R1 first interval", int'(out_value), 5);
        @(negedge clk);
        // R6: strobe lasts one cycle
        check("R6 strobe single", int'(out_valid), 0);
        // R12: value held
        check("R12 hold value", int'(out_value), 5);

        // R2 and R4: both carry codes, flagged completion
        send(8'h00);
        check("R2 no strobe on 0x00", int'(out_valid), 0);
        send(8'h80);
        check("R2 no strobe on 0x80", int'(out_valid), 0);
        send(8'h85);
        check("R2 two carries", int'(out_value), 259);
        check("R4 flag set", int'(out_flag), 1);

        // R5: cleared after output
        send(8'h03);
        check("R5 cleared", int'(out_value), 3);
        check("R4 flag clear", int'(out_flag), 0);

        // R8: ignored while in_valid low
        in_byte = 8'h00;
        repeat (3) @(negedge clk);
        in_byte = 8'h7F;
        @(negedge clk);
        check("R8 no strobe", int'(out_valid), 0);
        send(8'h01);
        check("R8 acc unchanged", int'(out_value), 1);

        // R7: back-to-back bytes
        send(8'h81);
        check("R7 burst 1", int'(out_value), 1);
        send(8'h02);
        check("R7 burst 2", int'(out_value), 2);
        check("R7 strobe 2", int'(out_valid), 1);
        send(8'h80);
        send(8'h7F);
        check("R7 burst 3", int'(out_value), 254);
        send(8'h7F);
        check("R7 burst 4", int'(out_value), 127);
        @(negedge clk);

        // R10 boundary: exactly 65535
        carries(516);
        send(8'h03);
        check("R10 exact max value", int'(out_value), 65535);
        check("R10 exact max no err", int'(err), 0);
        // R10: final addition overflows
        carries(516);
        send(8'h04);
        check("R10 saturated value", int'(out_value), 65535);
        check("R10 err set", int'(err), 1);
        // R11: sticky
        send(8'h09);
        check("R11 value ok", int'(out_value), 9);
        check("R11 err sticky", int'(err), 1);
        do_reset();
        check("R11 err cleared by reset", int'(err), 0);

        // R9: carry overflow
        carries(517);
        check("R9 err on carry", int'(err), 1);
        check("R9 no strobe", int'(out_valid), 0);
        send(8'h01);
        check("R9 saturated", int'(out_value), 65535);
        send(8'h02);
        check("R9 cleared after", int'(out_value), 2);
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule